// File: doc/BRIEF.md
# Broadcast Vector Multiply-Accumulate Array

This block is the arithmetic core of a vector accelerator. It multiplies one eight-element feature vector against an eight-by-eight weight matrix on every enabled clock cycle, which is 64 signed 8-bit multiplies per cycle. The products go into eight narrow accumulators, one for each output lane. The feature vector is copied to all eight lanes. Each lane pairs it with its own row of eight weights, forms the dot product, and adds that sum into its accumulator.

Both operand registers are loaded by plain write strobes. A write may share a cycle with a multiply-accumulate, so a new feature vector and a new weight matrix can arrive every cycle while the array completes one vector operation per cycle. A clear input starts a fresh accumulation. When the clear comes together with the enable, the first sum is loaded in place of the old total, so starting a new batch costs no extra cycle. The accumulators are always visible on a flat read-out bus.

The datapath has no sequencing of its own. It has one implicit mode per cycle, chosen by {acc_clr, mac_en}: HOLD (00), ACCUMULATE (01), CLEAR (10) and RESTART (11). Any mode may follow any other.

Top module: `vmac_array`

## Requirements
- R1: While rst_n is low, and after it is released, every accumulator, the feature register and the weight register read zero until they are written.
- R2: With mac_en high and acc_clr low, accumulator i (acc_out bits [i*18+17 : i*18]) gains the sum over j of feature[j] x weight[i*8+j]. Feature element j is feat_in bits [j*8+7 : j*8]. Weight element k is wgt_in bits [k*8+7 : k*8]. All operands are signed two's complement.
- R3: Accumulation wraps modulo 2^18 and never saturates.
- R4: With acc_clr high and mac_en low, every accumulator becomes zero at the next edge.
- R5: With acc_clr and mac_en both high, every accumulator is loaded with its new dot product, and the previous value is discarded.
- R6: An operand write in the same cycle as a multiply-accumulate is used only from the next cycle's multiply-accumulate onward. The current one uses the previously stored operands.
- R7: With mac_en and acc_clr both low, the accumulators keep their values, even when either operand register is being written.
- R8: Writing one operand register leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| feat_wr | input | 1 | Write strobe for the feature register |
| feat_in | input | 64 | Eight signed 8-bit feature elements |
| wgt_wr | input | 1 | Write strobe for the weight register |
| wgt_in | input | 512 | Sixty-four signed 8-bit weights, row i at elements i*8..i*8+7 |
| mac_en | input | 1 | Perform one vector multiply-accumulate this cycle |
| acc_clr | input | 1 | Clear accumulators (restart when mac_en is also high) |
| acc_out | output | 144 | Eight 18-bit accumulators, lane i at bits i*18 upward |

## Verification
A table of feature vectors and weight seeds covers several cases: mixed-sign elements, all-positive and all-negative features, and a zero feature. Together these separate a correct signed multiply from an unsigned one, and show whether each lane is fed its own weight row rather than a neighbour's. Alternating restart and accumulate entries tell a loaded sum apart from an added one. All operands at -128 push an accumulator across 2^17 and then to exactly 2^18, which exposes saturation or a widened accumulator. Operand writes placed in the same cycle as a multiply, and in idle cycles, show whether the operands are taken one cycle too early and whether an idle write disturbs the totals.

// File: rtl/vmac_pkg.sv
package vmac_pkg;
    localparam int unsigned DEF_LANES = 8;
    localparam int unsigned DEF_ELEMS = 8;
    localparam int unsigned DEF_OPW   = 8;
    localparam int unsigned DEF_ACCW  = 18;

    // Per-cycle accumulator mode, encoded as {acc_clr, mac_en}
    typedef enum logic [1:0] {
        MODE_HOLD    = 2'b00,
        MODE_ACCUM   = 2'b01,
        MODE_CLEAR   = 2'b10,
        MODE_RESTART = 2'b11
    } acc_mode_e;
endpackage

// File: rtl/vmac_operand_regs.sv
module vmac_operand_regs #(
    parameter int unsigned LANES = 8,
    parameter int unsigned ELEMS = 8,
    parameter int unsigned OPW   = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         feat_wr,
    input  logic [ELEMS*OPW-1:0]         feat_in,
    input  logic                         wgt_wr,
    input  logic [LANES*ELEMS*OPW-1:0]   wgt_in,
    output logic [ELEMS*OPW-1:0]         feat_q,
    output logic [LANES*ELEMS*OPW-1:0]   wgt_q
);
    localparam int unsigned FW = ELEMS * OPW;
    localparam int unsigned WW = LANES * FW;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            feat_q <= '0;
        end else if (feat_wr) begin
            feat_q <= feat_in;
        end
    end

    // One write enable per weight row keeps the fan-out of the strobe local
    for (genvar r = 0; r < LANES; r++) begin : g_row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                wgt_q[r*FW +: FW] <= '0;
            end else if (wgt_wr) begin
                wgt_q[r*FW +: FW] <= wgt_in[r*FW +: FW];
            end
        end
    end

    p_feat_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !feat_wr |=> $stable(feat_q));
    p_wgt_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wgt_wr |=> $stable(wgt_q));
    p_feat_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
        feat_wr |=> feat_q == $past(feat_in));

    logic unused_ww;
    assign unused_ww = (WW == 0);
endmodule

// File: rtl/vmac_lane.sv
module vmac_lane
    import vmac_pkg::*;
#(
    parameter int unsigned ELEMS = 8,
    parameter int unsigned OPW   = 8,
    parameter int unsigned ACCW  = 18
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mac_en,
    input  logic                   acc_clr,
    input  logic [ELEMS*OPW-1:0]   feat,
    input  logic [ELEMS*OPW-1:0]   wrow,
    output logic [ACCW-1:0]        acc
);
    localparam int unsigned PRODW = 2 * OPW;
    localparam int unsigned SUMW  = PRODW + $clog2(ELEMS);
    localparam int unsigned WIDE  = (SUMW > ACCW) ? SUMW : ACCW;

    logic signed [WIDE-1:0] dot_wide;
    logic [ACCW-1:0]        dot;
    logic [ACCW-1:0]        acc_nx;
    acc_mode_e              mode;

    always_comb begin
        logic signed [PRODW-1:0] prod;
        dot_wide = '0;
        for (int j = 0; j < ELEMS; j++) begin
            prod     = $signed(feat[j*OPW +: OPW]) * $signed(wrow[j*OPW +: OPW]);
            dot_wide = dot_wide + WIDE'(prod);
        end
        dot = dot_wide[ACCW-1:0];
    end

    assign mode = acc_mode_e'({acc_clr, mac_en});

    always_comb begin
        unique case (mode)
            MODE_HOLD:    acc_nx = acc;
            MODE_ACCUM:   acc_nx = acc + dot;
            MODE_CLEAR:   acc_nx = '0;
            MODE_RESTART: acc_nx = dot;
            default:      acc_nx = acc;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else begin
            acc <= acc_nx;
        end
    end

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mac_en && !acc_clr) |=> $stable(acc));
    p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_clr && !mac_en) |=> acc == '0);
    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_clr && mac_en) |=> acc == $past(dot));
    p_wrap_accum_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_en && !acc_clr) |=> acc == ACCW'($past(acc) + $past(dot)));
endmodule

// File: rtl/vmac_array.sv
module vmac_array
    import vmac_pkg::*;
#(
    parameter int unsigned LANES = DEF_LANES,
    parameter int unsigned ELEMS = DEF_ELEMS,
    parameter int unsigned OPW   = DEF_OPW,
    parameter int unsigned ACCW  = DEF_ACCW
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         feat_wr,
    input  logic [ELEMS*OPW-1:0]         feat_in,
    input  logic                         wgt_wr,
    input  logic [LANES*ELEMS*OPW-1:0]   wgt_in,
    input  logic                         mac_en,
    input  logic                         acc_clr,
    output logic [LANES*ACCW-1:0]        acc_out
);
    localparam int unsigned FW = ELEMS * OPW;

    logic [FW-1:0]       feat_q;
    logic [LANES*FW-1:0] wgt_q;

    vmac_operand_regs #(
        .LANES (LANES),
        .ELEMS (ELEMS),
        .OPW   (OPW)
    ) u_ops (
        .clk     (clk),
        .rst_n   (rst_n),
        .feat_wr (feat_wr),
        .feat_in (feat_in),
        .wgt_wr  (wgt_wr),
        .wgt_in  (wgt_in),
        .feat_q  (feat_q),
        .wgt_q   (wgt_q)
    );

    // Feature vector fans out unchanged to every lane; each lane gets its weight row
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        vmac_lane #(
            .ELEMS (ELEMS),
            .OPW   (OPW),
            .ACCW  (ACCW)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .mac_en  (mac_en),
            .acc_clr (acc_clr),
            .feat    (feat_q),
            .wrow    (wgt_q[i*FW +: FW]),
            .acc     (acc_out[i*ACCW +: ACCW])
        );
    end

    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (acc_out == '0 || !rst_n));
endmodule

// File: tb/vmac_array_tb.sv
module vmac_array_tb;
    localparam int L = 8;
    localparam int E = 8;
    localparam int AW = 18;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           feat_wr = 1'b0;
    logic [63:0]    feat_in = '0;
    logic           wgt_wr = 1'b0;
    logic [511:0]   wgt_in = '0;
    logic           mac_en = 1'b0;
    logic           acc_clr = 1'b0;
    logic [143:0]   acc_out;

    int checks = 0;
    int failures = 0;

    // Model of what the requirements say the registers hold
    logic [63:0]  m_feat = '0;
    logic [511:0] m_wgt  = '0;
    logic [AW-1:0] m_acc [L];

    // Stimulus table: {feature vector, weight seed, restart flag}
    localparam logic [72:0] VEC [6] = '{
        {64'h7F80_01FF_3C_C4_05_FB, 8'd1,  1'b1},
        {64'h1020_3040_5060_7070, 8'd9,  1'b0},
        {64'hF0E0_D0C0_B0A0_9080, 8'd23, 1'b0},
        {64'h0102_0304_FCFD_FEFF, 8'd4,  1'b1},
        {64'h0000_0000_0000_0000, 8'd77, 1'b0},
        {64'h7F7F_8080_7F80_807F, 8'd51, 1'b0}
    };

    vmac_array u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .feat_wr (feat_wr),
        .feat_in (feat_in),
        .wgt_wr  (wgt_wr),
        .wgt_in  (wgt_in),
        .mac_en  (mac_en),
        .acc_clr (acc_clr),
        .acc_out (acc_out)
    );

    always #10 clk = ~clk;

    function automatic logic [511:0] wgen(input int seed);
        logic [511:0] w;
        for (int k = 0; k < 64; k++) w[k*8 +: 8] = 8'(seed * 7 + k * 13 + 3);
        return w;
    endfunction

    function automatic logic [AW-1:0] mdot(input int lane, input logic [63:0] f,
                                           input logic [511:0] w);
        int s = 0;
        for (int j = 0; j < E; j++)
            s += int'($signed(f[j*8 +: 8])) * int'($signed(w[(lane*E+j)*8 +: 8]));
        return AW'(s);
    endfunction

    // One cycle of stimulus, driven at the falling edge; model follows the rules
    task automatic cyc(input logic fw, input logic [63:0] f, input logic ww,
                       input logic [511:0] w, input logic mac, input logic clr);
        @(negedge clk);
        feat_wr = fw; feat_in = f; wgt_wr = ww; wgt_in = w;
        mac_en = mac; acc_clr = clr;
        for (int i = 0; i < L; i++) begin
            if (mac && clr)      m_acc[i] = mdot(i, m_feat, m_wgt);
            else if (mac)        m_acc[i] = m_acc[i] + mdot(i, m_feat, m_wgt);
            else if (clr)        m_acc[i] = '0;
        end
        if (fw) m_feat = f;
        if (ww) m_wgt = w;
    endtask

    task automatic check_all(input string tag);
        @(negedge clk);
        feat_wr = 0; wgt_wr = 0; mac_en = 0; acc_clr = 0;
        for (int i = 0; i < L; i++) begin
            checks++;
            if (acc_out[i*AW +: AW] !== m_acc[i]) begin
                failures++;
                $display("FAIL %s lane %0d actual=%h expected=%h", tag, i,
                         acc_out[i*AW +: AW], m_acc[i]);
            end
        end
    endtask

    initial begin
        #(20 * 150000);
        checks++; failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < L; i++) m_acc[i] = '0;
        repeat (3) @(posedge clk);
        #5;
        checks++;
        if (acc_out !== '0) begin
            failures++;
            $display("FAIL R1 during reset actual=%h expected=0", acc_out);
        end
        @(negedge clk); rst_n = 1'b1;
        // R1: a multiply with reset-state operands must leave zero
        cyc(0, '0, 0, '0, 1, 0);
        check_all("R1 zero operands after reset");

        // Table walk: load, then multiply (restart or accumulate) R2 R5
        for (int n = 0; n < 6; n++) begin
            cyc(1, VEC[n][72:9], 1, wgen(int'(VEC[n][8:1])), 0, 0);
            cyc(0, '0, 0, '0, 1, VEC[n][0]);
            check_all(VEC[n][0] ? "R5 restart entry" : "R2 accumulate entry");
        end

        // R6: load in same cycle as multiply uses old operands
        cyc(1, 64'h0101_0101_0101_0101, 1, wgen(2), 0, 0);
        cyc(1, 64'hFF02_FF02_FF02_FF02, 1, wgen(40), 1, 1);
        check_all("R6 old operands used");
        cyc(0, '0, 0, '0, 1, 0);
        check_all("R6 new operands next cycle");

        // R7: idle cycles with operand writes keep totals
        cyc(1, 64'h1111_2222_3333_4444, 1, wgen(99), 0, 0);
        cyc(1, 64'h5555_6666_7777_0808, 0, '0, 0, 0);
        check_all("R7 hold under writes");

        // R8: weight-only write keeps feature, feature-only keeps weights
        cyc(0, 64'h0, 1, wgen(12), 0, 0);
        cyc(0, '0, 0, '0, 1, 1);
        check_all("R8 feature kept on weight write");
        cyc(1, 64'h0302_0100_FFFE_FDFC, 0, '0, 0, 0);
        cyc(0, '0, 0, '0, 1, 1);
        check_all("R8 weights kept on feature write");

        // R4: clear alone
        cyc(0, '0, 0, '0, 0, 1);
        check_all("R4 clear alone");

        // R3: -128 x -128 x 8 = 2^17 per step; two steps wrap to 0
        cyc(1, {8{8'h80}}, 1, {64{8'h80}}, 0, 0);
        cyc(0, '0, 0, '0, 1, 0);
        check_all("R3 first step 2^17");
        cyc(0, '0, 0, '0, 1, 0);
        check_all("R3 wrap to zero");
        cyc(0, '0, 0, '0, 1, 0);
        check_all("R3 after wrap");

        // R1: reset mid-run clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_feat = '0; m_wgt = '0;
        for (int i = 0; i < L; i++) m_acc[i] = '0;
        cyc(0, '0, 0, '0, 1, 0);
        check_all("R1 reset clears operands");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule